// File: doc/BRIEF.md
# Off-core response event filter counter

This block counts the transactions that a processor core sends out to the shared memory system. Each completed transaction is reported on one cycle with a one-hot request class and a one-hot response source. One 16-bit filter register is shared by all counters. Its low byte selects the request classes that count and its high byte selects the response sources that count. A transaction qualifies only when the filter holds both its request bit and its response bit.

There are four general counters, each 48 bits wide, and each has a 64-bit event-select register. A counter advances on a qualifying transaction only when its select register is enabled and carries the off-core response event code and unit mask. Software reaches the filter, the select registers and the counters through a single-cycle register port. Reads are combinational and writes take effect at the clock edge.

Top module: `xcore_resp_pmu`

## Requirements
- R1: After a synchronous reset the filter register, every select register and every counter read back as zero.
- R2: The filter register is at address 0x1A6. Writes to its bit 11 and to bits 63:16 are dropped, and those bits always read back as zero.
- R3: Filter bits 7:0 select request classes by bit position: demand data read, demand read-for-ownership, demand instruction fetch, writeback, prefetcher data read, prefetcher read-for-ownership, prefetcher instruction fetch, other. Filter bits 15:8 select response sources: shared-cache hit, other-core clean snoop hit, other-core modified hit, reserved, remote cache forward, remote DRAM, local DRAM, non-DRAM. A valid transaction whose request bit and response bit are both set in the filter adds exactly one to each enabled, matching counter.
- R4: A transaction whose request bit or response bit is clear in the filter never counts, so a filter with an empty request byte or an empty response byte counts nothing.
- R5: A counter only counts when its select register holds event code 0xB7 in bits 7:0 and unit mask 0x01 in bits 15:8. Any other code or mask leaves it unchanged.
- R6: Bit 22 of a select register enables its counter. While that bit is clear, the counter holds its value.
- R7: When a filter write and a transaction happen in the same cycle, the transaction is judged against the filter value from before the write.
- R8: Counters are 48 bits wide, read back with bits 63:48 as zero, and wrap from 2^48-1 to zero.
- R9: Select register n is at address 0x190+n and counter n is at 0x0D0+n, both read/write. A counter write in the same cycle as a qualifying transaction loads the written value, and the transaction is not added.
- R10: All four counters share the one filter register and each counts on its own. Reading an address that maps to no register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | A transaction completes this cycle |
| txn_req | input | 8 | One-hot request class |
| txn_rsp | input | 8 | One-hot response source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |

## Verification
The bench builds the block with its default parameters: four counters, 48-bit counters, a 12-bit address and the default address map. Because the counters are full width, the wrap check preloads a counter with 2^48-1 through the port instead of counting up to it. That one preload puts the rollover to zero within a few cycles. With all four slots present, the bench can show that one shared filter drives several counters at once while a disabled counter next to them stays idle.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

    localparam int REQ_W = 8;
    localparam int RSP_W = 8;
    localparam int REG_W = 64;

    // event code and unit mask that route the filter to a counter
    localparam logic [7:0] OCR_EVT_CODE = 8'hB7;
    localparam logic [7:0] OCR_UMASK    = 8'h01;
    localparam int         SEL_EN_BIT   = 22;

    // reserved response source inside the response byte
    localparam int RSP_RSVD_BIT = 3;

    // filter layout: request byte low, response byte high
    typedef struct packed {
        logic [RSP_W-1:0] rsp;
        logic [REQ_W-1:0] req;
    } filt_cfg_t;

    localparam int CFG_W = $bits(filt_cfg_t);

    typedef struct packed {
        logic             valid;
        logic [REQ_W-1:0] req;
        logic [RSP_W-1:0] rsp;
    } txn_t;

    // drop the reserved response bit from a written value
    function automatic filt_cfg_t cfg_clean(input logic [CFG_W-1:0] w);
        filt_cfg_t c;
        c = filt_cfg_t'(w);
        c.rsp[RSP_RSVD_BIT] = 1'b0;
        return c;
    endfunction

    // true when the select value names the off-core response event
    function automatic logic sel_is_ocr(input logic [15:0] s);
        return (s[7:0] == OCR_EVT_CODE) && (s[15:8] == OCR_UMASK);
    endfunction

endpackage

// File: rtl/ocr_cfg_reg.sv
module ocr_cfg_reg
    import ocr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output filt_cfg_t        cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_clean(wr_data);
        end
    end

endmodule

// File: rtl/ocr_match.sv
module ocr_match
    import ocr_pkg::*;
(
    input  txn_t      txn,
    input  filt_cfg_t cfg,
    output logic      hit
);

    logic req_sel;
    logic rsp_sel;

    always_comb begin
        req_sel = |(txn.req & cfg.req);
        rsp_sel = |(txn.rsp & cfg.rsp);
        hit     = txn.valid && req_sel && rsp_sel;
    end

endmodule

// File: rtl/ocr_ctr_slice.sv
module ocr_ctr_slice
    import ocr_pkg::*;
#(
    parameter int CTR_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic             cnt_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             hit,
    output logic [REG_W-1:0] sel_q,
    output logic [CTR_W-1:0] cnt_q
);

    logic armed;

    always_comb begin
        armed = sel_q[SEL_EN_BIT] && sel_is_ocr(sel_q[15:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata[CTR_W-1:0];
        end else if (hit && armed) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/xcore_resp_pmu.sv
module xcore_resp_pmu
    import ocr_pkg::*;
#(
    parameter int                NUM_CTR  = 4,
    parameter int                CTR_W    = 48,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 'h1A6,
    parameter logic [ADDR_W-1:0] SEL_BASE = 'h190,
    parameter logic [ADDR_W-1:0] CTR_BASE = 'h0D0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_valid,
    input  logic [REQ_W-1:0]  txn_req,
    input  logic [RSP_W-1:0]  txn_rsp,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam int PAD_W = REG_W - CTR_W;

    filt_cfg_t                          cfg_q;
    txn_t                               txn;
    logic                               hit;
    logic                               cfg_we;
    logic [NUM_CTR-1:0][REG_W-1:0]      sel_vals;
    logic [NUM_CTR-1:0][CTR_W-1:0]      ctr_vals;

    always_comb begin
        txn.valid = txn_valid;
        txn.req   = txn_req;
        txn.rsp   = txn_rsp;
        cfg_we    = reg_we && (reg_addr == CFG_ADDR);
    end

    ocr_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (reg_wdata[CFG_W-1:0]),
        .cfg_q   (cfg_q)
    );

    ocr_match u_match (
        .txn (txn),
        .cfg (cfg_q),
        .hit (hit)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slice
        logic sel_we_g;
        logic cnt_we_g;

        always_comb begin
            sel_we_g = reg_we && (reg_addr == ADDR_W'(SEL_BASE + g));
            cnt_we_g = reg_we && (reg_addr == ADDR_W'(CTR_BASE + g));
        end

        ocr_ctr_slice #(.CTR_W(CTR_W)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .sel_we (sel_we_g),
            .cnt_we (cnt_we_g),
            .wdata  (reg_wdata),
            .hit    (hit),
            .sel_q  (sel_vals[g]),
            .cnt_q  (ctr_vals[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CFG_ADDR) begin
            reg_rdata = {{(REG_W-CFG_W){1'b0}}, cfg_q};
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == ADDR_W'(SEL_BASE + i)) begin
                reg_rdata = sel_vals[i];
            end
            if (reg_addr == ADDR_W'(CTR_BASE + i)) begin
                reg_rdata = {{PAD_W{1'b0}}, ctr_vals[i]};
            end
        end
    end

endmodule

// File: rtl/ocr_pmu_chk.sv
module ocr_pmu_chk #(
    parameter int                NUM_CTR  = 4,
    parameter int                CTR_W    = 48,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 'h1A6,
    parameter logic [ADDR_W-1:0] CTR_BASE = 'h0D0
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          txn_valid,
    input logic [7:0]                    txn_req,
    input logic [7:0]                    txn_rsp,
    input logic                          reg_we,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [63:0]                   reg_rdata,
    input logic [15:0]                   cfg_q,
    input logic [NUM_CTR-1:0][63:0]      sel_vals,
    input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_vals
);

    logic qual;
    always_comb begin
        qual = txn_valid && (|(txn_req & cfg_q[7:0])) && (|(txn_rsp & cfg_q[15:8]));
    end

    // R2
    cfg_rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == CFG_ADDR) |-> ((reg_rdata[63:16] == '0) && (reg_rdata[11] == 1'b0)));

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
        logic wr_g;
        always_comb begin
            wr_g = reg_we && (reg_addr == ADDR_W'(CTR_BASE + g));
        end

        // R4
        unmatched_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!wr_g && !qual) |=> $stable(ctr_vals[g]));

        // R5
        wrong_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!wr_g && (sel_vals[g][15:0] != 16'h01B7)) |=> $stable(ctr_vals[g]));

        // R6
        disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!wr_g && !sel_vals[g][22]) |=> $stable(ctr_vals[g]));

        // R8
        step_one_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_g |=> ((ctr_vals[g] == $past(ctr_vals[g])) ||
                       (ctr_vals[g] == CTR_W'($past(ctr_vals[g]) + 1'b1))));
    end

endmodule

bind xcore_resp_pmu ocr_pmu_chk #(
    .NUM_CTR  (NUM_CTR),
    .CTR_W    (CTR_W),
    .ADDR_W   (ADDR_W),
    .CFG_ADDR (CFG_ADDR),
    .CTR_BASE (CTR_BASE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .txn_valid (txn_valid),
    .txn_req   (txn_req),
    .txn_rsp   (txn_rsp),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .cfg_q     (cfg_q),
    .sel_vals  (sel_vals),
    .ctr_vals  (ctr_vals)
);

// File: tb/xcore_resp_pmu_tb.sv
module xcore_resp_pmu_tb_top;

    localparam logic [11:0] A_CFG = 12'h1A6;
    localparam logic [11:0] A_SEL = 12'h190;
    localparam logic [11:0] A_CTR = 12'h0D0;
    localparam logic [63:0] SEL_ON = 64'h0000_0000_0040_01B7;

    // {filter[15:0], request[7:0], response[7:0], expected increment}
    localparam int NV = 9;
    localparam logic [32:0] VEC [NV] = '{
        {16'h0101, 8'h01, 8'h01, 1'b1},
        {16'h0101, 8'h02, 8'h01, 1'b0},
        {16'h0101, 8'h01, 8'h02, 1'b0},
        {16'hFF00, 8'h01, 8'h01, 1'b0},
        {16'h00FF, 8'h80, 8'h80, 1'b0},
        {16'h8080, 8'h80, 8'h80, 1'b1},
        {16'h0824, 8'h04, 8'h08, 1'b0},
        {16'h6030, 8'h10, 8'h40, 1'b1},
        {16'hFFFF, 8'h40, 8'h20, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_valid = 1'b0;
    logic [7:0]  txn_req = '0;
    logic [7:0]  txn_rsp = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    xcore_resp_pmu dut_i (
        .clk       (clk),
        .rst       (rst),
        .txn_valid (txn_valid),
        .txn_req   (txn_req),
        .txn_rsp   (txn_rsp),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic txn(input logic [7:0] rq, input logic [7:0] rs);
        @(negedge clk);
        txn_valid = 1'b1; txn_req = rq; txn_rsp = rs;
        @(negedge clk);
        txn_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_CFG, v);       chk("R1 filter", v, 64'h0);
        rd(A_SEL + 12'd2, v); chk("R1 select2", v, 64'h0);
        rd(A_CTR + 12'd3, v); chk("R1 counter3", v, 64'h0);

        // R3 R4: vector table on counter 0
        wr(A_SEL, SEL_ON);
        for (int i = 0; i < NV; i++) begin
            wr(A_CFG, {48'h0, VEC[i][32:17]});
            wr(A_CTR, 64'h0);
            txn(VEC[i][16:9], VEC[i][8:1]);
            rd(A_CTR, v);
            chk(VEC[i][0] ? "R3 vector" : "R4 vector", v, {63'h0, VEC[i][0]});
        end

        // R2: reserved filter bits dropped
        wr(A_CFG, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_CFG, v); chk("R2 readback", v, 64'h0000_0000_0000_F7FF);

        // R5: wrong code, wrong mask
        wr(A_CTR, 64'h0);
        wr(A_SEL, 64'h0000_0000_0040_01B6);
        txn(8'h01, 8'h01);
        rd(A_CTR, v); chk("R5 code", v, 64'h0);
        wr(A_SEL, 64'h0000_0000_0040_02B7);
        txn(8'h01, 8'h01);
        rd(A_CTR, v); chk("R5 mask", v, 64'h0);

        // R6: enable clear holds
        wr(A_SEL, 64'h0000_0000_0000_01B7);
        txn(8'h01, 8'h01);
        rd(A_CTR, v); chk("R6 disabled", v, 64'h0);

        // R7: same-cycle filter write uses old filter
        wr(A_SEL, SEL_ON);
        wr(A_CFG, 64'h0101);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CFG; reg_wdata = 64'h0;
        txn_valid = 1'b1; txn_req = 8'h01; txn_rsp = 8'h01;
        @(negedge clk);
        reg_we = 1'b0; txn_valid = 1'b0;
        rd(A_CTR, v); chk("R7 old filter", v, 64'h1);
        txn(8'h01, 8'h01);
        rd(A_CTR, v); chk("R7 new filter", v, 64'h1);

        // R8: wrap
        wr(A_CFG, 64'h0101);
        wr(A_CTR, 64'h0000_FFFF_FFFF_FFFF);
        rd(A_CTR, v); chk("R8 preload", v, 64'h0000_FFFF_FFFF_FFFF);
        txn(8'h01, 8'h01);
        rd(A_CTR, v); chk("R8 wrap", v, 64'h0);

        // R9: counter write beats increment
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CTR; reg_wdata = 64'h5;
        txn_valid = 1'b1; txn_req = 8'h01; txn_rsp = 8'h01;
        @(negedge clk);
        reg_we = 1'b0; txn_valid = 1'b0;
        rd(A_CTR, v); chk("R9 write wins", v, 64'h5);

        // R10: shared filter, independent counters, unmapped read
        wr(A_SEL + 12'd2, SEL_ON);
        wr(A_SEL + 12'd3, SEL_ON);
        txn(8'h01, 8'h01);
        txn(8'h01, 8'h01);
        rd(A_CTR + 12'd1, v); chk("R10 counter1 idle", v, 64'h0);
        rd(A_CTR + 12'd2, v); chk("R10 counter2", v, 64'h2);
        rd(A_CTR + 12'd3, v); chk("R10 counter3", v, 64'h2);
        rd(A_CTR, v);         chk("R10 counter0", v, 64'h7);
        rd(12'h0D7, v);       chk("R10 unmapped", v, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule